// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block is the transmit half of a clocked synchronous serial port. It sends 8-bit frames, least significant bit first, with no start, stop or parity bits. It drives a data line and a bit clock that it generates itself. A holding register sits in front of a shift register. While one frame is leaving the shift register, the next byte can already be written to the holding register, so consecutive frames leave the pin with no idle clock between them. The bit rate comes from a one-cycle strobe, `bit_tick`. Every strobe toggles the serial clock once, so a bit lasts two strobes.

Firmware drives the block through a small register port. The handshake has two steps. First the status word must be read while the empty flag is 1. Then the byte is written and the empty flag is cleared, and only that clear releases the byte for sending. A DMA engine can feed the block instead. It answers the empty request with an acknowledge pulse that carries the byte, and this clears the flag in hardware. There are two interrupt requests. The empty request asks for more data. The end request reports that the line has fully drained.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, and in any cycle that follows a cycle with the enable bit at 0, the empty flag and the end flag both read 1, `ser_clk` and `ser_dat` are high, and `txi` and `tei` are 0. The register map is as follows. Address 0 is control: bit 0 is enable, bit 1 is the empty-interrupt enable, and bit 2 is the end-interrupt enable. Address 1 is status: bit 0 is the empty flag and bit 1 is the end flag. Address 2 is the data holding register. Reads return data one cycle after `reg_rd`.
- R2: A frame is DATA_W bits sent bit 0 first. `ser_dat` changes only when `ser_clk` falls, and the receiver takes each bit on the rising edge.
- R3: `txi` equals empty flag AND empty-interrupt enable AND enable. `dma_req` is the same signal.
- R4: Writing the data register alone does not start a frame. No clock edge appears until the empty flag is cleared.
- R5: Writing a 0 to status bit 0 clears the empty flag only if status was read with the empty flag at 1 after the flag last became 1. Otherwise the write is ignored.
- R6: A `dma_ack` pulse while the empty flag is 1 loads `dma_data` into the holding register and clears both the empty flag and the end flag.
- R7: On the first `bit_tick` after the empty flag is cleared, the byte moves to the shift register. In that same cycle the empty flag returns to 1, `ser_clk` falls and bit 0 appears on `ser_dat`.
- R8: If the empty flag is 0 when the last bit's period ends, the next frame's first falling edge follows at once. Consecutive rising edges stay two strobes apart across the frame boundary.
- R9: When the last bit's period ends with the empty flag at 1, the end flag is set and `ser_clk` stays high. `tei` equals end flag AND end-interrupt enable AND enable.
- R10: A data-register write, a DMA write or an honoured empty-flag clear clears the end flag.
- R11: `ser_clk` toggles only while a frame is shifting. It falls exactly DATA_W times per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Strobe; each one toggles the serial clock |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| dma_req | output | 1 | DMA request (same as txi) |
| dma_ack | input | 1 | DMA write strobe |
| dma_data | input | DATA_W | DMA write data |
| ser_clk | output | 1 | Serial bit clock, idle high |
| ser_dat | output | 1 | Serial data |
| txi | output | 1 | Empty interrupt request |
| tei | output | 1 | End interrupt request |

## Verification
The bench builds the block at its default DATA_W of 8 and pulses `bit_tick` every third clock. Each serial bit therefore spans six clocks. That leaves room for the bench to run the full read, write and clear handshake for a second byte inside one frame, which is what makes the gapless back-to-back case reachable. The same spacing lets the bench measure the boundary between frames as exactly one bit period. A scoreboard queue holds the expected bytes, and a monitor rebuilds each frame from the rising clock edges.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
  localparam int C_EN   = 0;
  localparam int C_TXIE = 1;
  localparam int C_TEIE = 2;
  localparam int S_EMPTY = 0;
  localparam int S_END   = 1;
endpackage

// File: rtl/sst_regs.sv
module sst_regs
  import sst_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              dma_ack,
  input  logic [DW-1:0]     dma_data,
  input  logic              load,
  input  logic              drained,
  output logic              tx_en,
  output logic [DW-1:0]     hold,
  output logic              empty,
  output logic              txi,
  output logic              tei
);
  logic txie, teie, tend, armed;
  logic [DW-1:0] rdata_q;
  logic sw_clr, dma_wr;

  assign sw_clr = tx_en && reg_wr && (reg_addr == A_STAT) &&
                  !reg_wdata[S_EMPTY] && armed && empty;
  assign dma_wr = tx_en && dma_ack && empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en <= 1'b0;
      txie  <= 1'b0;
      teie  <= 1'b0;
      hold  <= '0;
      empty <= 1'b1;
      tend  <= 1'b1;
      armed <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) begin
        tx_en <= reg_wdata[C_EN];
        txie  <= reg_wdata[C_TXIE];
        teie  <= reg_wdata[C_TEIE];
      end
      if (reg_wr && reg_addr == A_DATA) hold <= reg_wdata;
      if (!tx_en) begin
        empty <= 1'b1;
        tend  <= 1'b1;
        armed <= 1'b0;
      end else begin
        if (load) empty <= 1'b1;
        if (drained) tend <= 1'b1;
        if (reg_rd && reg_addr == A_STAT && empty) armed <= 1'b1;
        if (reg_wr && reg_addr == A_DATA) tend <= 1'b0;
        if (dma_wr) begin
          hold  <= dma_data;
          empty <= 1'b0;
          tend  <= 1'b0;
          armed <= 1'b0;
        end
        if (sw_clr) begin
          empty <= 1'b0;
          tend  <= 1'b0;
          armed <= 1'b0;
        end
      end
      if (reg_rd) begin
        rdata_q <= '0;
        case (reg_addr)
          A_CTRL: begin
            rdata_q[C_EN]   <= tx_en;
            rdata_q[C_TXIE] <= txie;
            rdata_q[C_TEIE] <= teie;
          end
          A_STAT: begin
            rdata_q[S_EMPTY] <= empty;
            rdata_q[S_END]   <= tend;
          end
          A_DATA:  rdata_q <= hold;
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign txi = empty && txie && tx_en;
  assign tei = tend && teie && tx_en;

  AST_OFF_FLAGS_SET: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (empty && tend)); // R1
  AST_LOAD_REFILLS: assert property (@(posedge clk) disable iff (rst)
    (load && tx_en) |=> empty); // R7
  AST_UNARMED_CLR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (tx_en && reg_wr && reg_addr == A_STAT && !reg_wdata[S_EMPTY] && !armed
     && empty && !dma_ack) |=> empty); // R5
  AST_DMA_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (tx_en && dma_ack && empty && !(reg_wr && reg_addr == A_CTRL))
    |=> (!empty && !tend)); // R6
  AST_END_IMPLIES_EMPTY: assert property (@(posedge clk) disable iff (rst)
    tend |-> empty); // R9
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          pending,
  input  logic [DW-1:0] hold,
  output logic          load,
  output logic          drained,
  output logic          ser_clk,
  output logic          ser_dat
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(DW - 1);

  logic [DW-1:0] sreg;
  logic [CW-1:0] idx;
  logic busy, last, fall_slot;

  assign last      = (idx == LAST_IDX);
  assign fall_slot = tick && tx_en && ser_clk;
  assign load      = fall_slot && (!busy || last) && pending;
  assign drained   = fall_slot && busy && last && !pending;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      sreg    <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      ser_clk <= 1'b1;
      ser_dat <= 1'b1;
    end else if (tick) begin
      if (ser_clk) begin
        if (load) begin
          sreg    <= hold;
          ser_dat <= hold[0];
          idx     <= '0;
          busy    <= 1'b1;
          ser_clk <= 1'b0;
        end else if (busy && !last) begin
          sreg    <= sreg >> 1;
          ser_dat <= sreg[1];
          idx     <= idx + 1'b1;
          ser_clk <= 1'b0;
        end else if (drained) begin
          busy <= 1'b0;
        end
      end else begin
        ser_clk <= 1'b1;
      end
    end
  end

  AST_CLK_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_clk); // R11
  AST_FALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_clk) |-> busy); // R11
  AST_RISE_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> $stable(ser_dat)); // R2
  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (fall_slot && busy && last && pending) |=> (!ser_clk && busy)); // R8
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic [DATA_W-1:0] dma_data,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              txi,
  output logic              tei
);
  logic tx_en, empty, load, drained;
  logic [DATA_W-1:0] hold;

  sst_regs #(.DW(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_ack(dma_ack), .dma_data(dma_data), .load(load),
    .drained(drained), .tx_en(tx_en), .hold(hold), .empty(empty),
    .txi(txi), .tei(tei)
  );

  sst_shifter #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .tick(bit_tick), .tx_en(tx_en),
    .pending(!empty), .hold(hold), .load(load), .drained(drained),
    .ser_clk(ser_clk), .ser_dat(ser_dat)
  );

  assign dma_req = txi;

  AST_DMA_REQ_IS_TXI: assert property (@(posedge clk) disable iff (rst)
    dma_req == txi); // R3
endmodule

// File: tb/sync_ser_tx_test.sv
module sync_ser_tx_test;
  localparam int DW = 8;
  localparam int TD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [DW-1:0] reg_wdata = '0, dma_data = '0;
  logic [DW-1:0] reg_rdata;
  logic dma_req, dma_ack = 1'b0;
  logic ser_clk, ser_dat, txi, tei;

  sync_ser_tx #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dma_req(dma_req), .dma_ack(dma_ack),
    .dma_data(dma_data), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .txi(txi), .tei(tei)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, rises = 0, falls = 0, frames = 0, contig = 0;
  int last_rise = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] dma_list[$];
  bit dma_on = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // tick strobe
  initial begin
    forever begin
      for (int i = 0; i < TD - 1; i++) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  // monitor: rebuilds frames on rising serial clock
  initial begin
    logic prev_clk;
    logic [DW-1:0] shreg;
    int bits;
    prev_clk = 1'b1;
    bits = 0;
    shreg = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (prev_clk && !ser_clk) falls++;
        if (!prev_clk && ser_clk) begin
          rises++;
          if (bits == 0 && frames > 0 && (cyc - last_rise) == 2 * TD) contig++;
          last_rise = cyc;
          shreg = {ser_dat, shreg[DW-1:1]};
          bits++;
          if (bits == DW) begin
            bits = 0;
            frames++;
            if (exp_q.size() == 0) chk(0, "R2 unexpected frame", shreg, 0);
            else begin
              logic [DW-1:0] e;
              e = exp_q.pop_front();
              chk(shreg == e, "R2 frame bits", shreg, e);
            end
          end
        end
      end
      prev_clk = ser_clk;
    end
  end

  // DMA responder
  initial begin
    forever begin
      @(negedge clk);
      if (dma_ack) dma_ack = 1'b0;
      else if (dma_on && dma_req && dma_list.size() > 0) begin
        dma_data = dma_list.pop_front();
        exp_q.push_back(dma_data);
        dma_ack = 1'b1;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic send_sw(input logic [DW-1:0] b);
    logic [DW-1:0] s;
    rd(2'd1, s);
    wr(2'd2, b);
    exp_q.push_back(b);
    wr(2'd1, '0);
  endtask

  task automatic wait_tei(input string req);
    int n;
    n = 0;
    while (!tei && n < 2000) begin @(negedge clk); n++; end
    chk(tei, req, tei, 1);
  endtask

  initial begin
    logic [DW-1:0] s;
    int f0, r0, c0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ser_clk == 1'b1, "R1 ser_clk idle", ser_clk, 1);
    chk(ser_dat == 1'b1, "R1 ser_dat idle", ser_dat, 1);
    chk(txi == 1'b0 && tei == 1'b0, "R1 irqs off", {txi, tei}, 0);
    rd(2'd1, s);
    chk(s[1:0] == 2'b11, "R1 flags after reset", s[1:0], 3);

    // enable with both interrupts
    wr(2'd0, 8'h07);
    @(negedge clk);
    chk(txi == 1'b1 && dma_req == 1'b1, "R3 txi when empty", {txi, dma_req}, 3);
    chk(tei == 1'b1, "R9 tei on enable", tei, 1);

    // R4 / R10: data write alone
    r0 = rises;
    wr(2'd2, 8'h5A);
    rd(2'd1, s);
    chk(s[1:0] == 2'b01, "R10 end cleared by data write", s[1:0], 1);
    repeat (40) @(negedge clk);
    chk(rises == r0 && ser_clk, "R4 no frame before clear", rises - r0, 0);

    // R5: unarmed clear ignored (fresh enable drops the arm)
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h07);
    wr(2'd1, '0);
    repeat (2) @(negedge clk);
    chk(txi == 1'b1, "R5 unarmed clear ignored", txi, 1);
    repeat (20) @(negedge clk);
    chk(rises == r0, "R5 no frame after unarmed clear", rises - r0, 0);

    // R7: single software frame, load alignment
    f0 = frames;
    rd(2'd1, s);
    wr(2'd2, 8'hA5);
    exp_q.push_back(8'hA5);
    wr(2'd1, '0);
    chk(txi == 1'b0, "R4 empty cleared", txi, 0);
    begin
      int n;
      n = 0;
      while (!txi && n < 50) begin @(negedge clk); n++; end
    end
    chk(txi && !ser_clk && ser_dat == 1'b1, "R7 load with first fall",
        {txi, ser_clk, ser_dat}, 5);
    wait_tei("R9 tei after frame");
    chk(frames == f0 + 1 && ser_clk, "R9 frame done, clock high", frames - f0, 1);

    // R8: back-to-back software frames
    c0 = contig;
    f0 = frames;
    send_sw(8'h3C);
    begin
      int n;
      n = 0;
      while (!txi && n < 50) begin @(negedge clk); n++; end
    end
    send_sw(8'hC3);
    @(negedge clk);
    wait_tei("R9 tei after pair");
    chk(frames == f0 + 2, "R9 pair drained", frames - f0, 2);
    chk(contig == c0 + 1, "R8 no gap between frames", contig - c0, 1);

    // R6: DMA feeds three frames
    c0 = contig;
    f0 = frames;
    dma_list.push_back(8'h81);
    dma_list.push_back(8'hFF);
    dma_list.push_back(8'h00);
    dma_on = 1;
    while (dma_list.size() > 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(tei == 1'b0, "R6 dma write clears end", tei, 0);
    wait_tei("R6 tei after dma");
    dma_on = 0;
    chk(frames == f0 + 3, "R6 dma frames", frames - f0, 3);
    chk(contig == c0 + 2, "R8 dma frames gapless", contig - c0, 2);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    chk(falls == DW * frames && rises == DW * frames, "R11 edges per frame",
        falls, DW * frames);

    // R1: disable
    wr(2'd0, 8'h00);
    @(negedge clk);
    rd(2'd1, s);
    chk(s[1:0] == 2'b11 && ser_dat && ser_clk && !txi && !tei,
        "R1 disabled state", s[1:0], 3);
    finish_run();
  end
endmodule